// File: doc/BRIEF.md
# TDM Slot Engine

This block runs the word-slot side of a time-division-multiplexed serial link. A frame-sync pulse starts a frame at slot 0. Each slot then lasts a configurable number of bit cycles (one bit per clock; bit-clock generation sits outside the block). For every slot, two independent enable bitmaps decide what happens. In the transmit direction, an enabled slot shifts a word out MSB first from a holding register, and a disabled slot releases the data pin: its output enable is low for the whole slot. In the receive direction, an enabled slot shifts a word in and hands it to a one-word receive buffer with a valid strobe and the slot index. A disabled receive slot is dropped without touching the buffer.

The transmit side asks for data one slot ahead, and only for slots that will actually transmit. A host answers the request by writing the holding register before the next slot begins. A global enable turns all slot selection on or off. A companding-law select is taken at each accepted frame sync and presented unchanged for the whole frame. It is the same for every active slot.

The controller is a three-state machine. IDLE means multichannel operation is off or no frame has started. SHIFT means bits of a slot are moving. DONE means the last slot of the frame has ended and the engine waits for sync. The transitions are:
- START: IDLE to SHIFT on an accepted sync.
- NEXT: SHIFT to SHIFT at the end of a slot that is not the last.
- END: SHIFT to DONE at the end of the last slot.
- RESYNC: SHIFT or DONE to SHIFT on an accepted sync, which restarts slot 0.
- OFF: any state to IDLE when the global enable is low. OFF takes priority over every other transition.

Top module: `tdm_slot_engine`

## Requirements
- R1: After reset, dt_oe, tx_req, rx_valid, rx_ovf and law_out are 0 and rx_data is 0.
- R2: When mc_en is 1, a cycle with fsync high makes the following cycle bit 0 of slot 0. Each slot lasts cfg_wlen+1 cycles, where cfg_wlen is valid in the range 2 to 15. After slot cfg_nslots, no slot is active until the next accepted fsync. An fsync in any state restarts slot 0.
- R3: During every cycle of a slot whose tx_mask bit is 1, dt_oe is 1. dt carries the low cfg_wlen+1 bits of the holding register as it stood when the slot began, MSB first.
- R4: During every cycle of a slot whose tx_mask bit is 0, dt_oe is 0 and dt is 0.
- R5: At the edge ending a slot whose rx_mask bit is 1, rx_valid pulses for one cycle. rx_data then holds the cfg_wlen+1 bits sampled from dr in that slot, with the first bit as MSB and the upper bits zero. rx_slot holds the slot index.
- R6: A slot whose rx_mask bit is 0 gives no rx_valid and leaves rx_data and rx_slot unchanged.
- R7: If a word is captured while the previous captured word has not been acknowledged by rx_rd (an rx_rd in the same cycle counts), rx_ovf pulses together with rx_valid, and the new word replaces the old one.
- R8: In the first cycle of each slot, tx_req is 1 exactly when the tx_mask bit of the following slot is 1. The following slot is slot+1, or 0 after slot cfg_nslots. tx_req_slot gives that index. A tx_wr in that cycle supplies the word for that slot.
- R9: With mc_en at 0, the engine is idle from the next cycle. fsync is ignored, and dt_oe, tx_req and rx_valid stay 0.
- R10: law_out takes cfg_law at each accepted fsync and holds it until the next accepted fsync.
- R11: Bit n of tx_mask and of rx_mask governs slot n, for every n from 0 to 127. Each 16-bit group covers slots 16g to 16g+15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_en | input | 1 | Global multichannel enable |
| fsync | input | 1 | Frame-sync pulse |
| cfg_nslots | input | 7 | Index of the last slot in a frame |
| cfg_wlen | input | 4 | Word length minus one |
| cfg_law | input | 1 | Companding-law select (0 and 1 pick the two laws) |
| tx_mask | input | 128 | Per-slot transmit enables |
| rx_mask | input | 128 | Per-slot receive enables |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 16 | Transmit word |
| tx_req | output | 1 | Request for the next slot's word |
| tx_req_slot | output | 7 | Slot index the request is for |
| dt | output | 1 | Serial transmit data |
| dt_oe | output | 1 | Output enable for the transmit pad |
| dr | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle strobe for a captured word |
| rx_data | output | 16 | Captured word, right-aligned |
| rx_slot | output | 7 | Slot index of the captured word |
| rx_rd | input | 1 | Host acknowledge of the buffered word |
| rx_ovf | output | 1 | Capture over an unacknowledged word |
| law_out | output | 1 | Companding law in force for the frame |

## Verification
The bench keeps its own model of the frame and compares every output on every clock. It goes after several corner cases:
- The wrap from the last slot to the request for slot 0. A design that got this wrong would ask for the wrong slot or miss the request.
- Masks with bits far above the first 16-bit group. A wrong index would capture the wrong slot numbers.
- A frame sync in the middle of a word. A design that failed to restart would keep shifting the stale slot.
- A capture while an older word is unread. Without the flag, overflow would pass silently.
- Dropping the global enable mid-frame, then pulsing sync while off. A design that ignored the enable would keep driving the pad or keep storing words.
- A change of the law select in the middle of a frame. This must not appear before the next sync.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } tdm_state_e;
endpackage

// File: rtl/tdm_slot_ctrl.sv
`timescale 1ns/1ps
module tdm_slot_ctrl
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] cfg_nslots,
    input  logic [BIT_W-1:0]  cfg_wlen,
    output tdm_state_e        state,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bitc,
    output logic              load,
    output logic              word_end,
    output logic [SLOT_W-1:0] next_slot
);
    tdm_state_e st_nxt;
    logic       fs_go;
    logic       last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nxt;
    end

    // outputs derived from the current state and counters
    always_comb begin
        fs_go     = mc_en & fsync;
        last      = (slot == cfg_nslots);
        word_end  = (state == ST_SHIFT) && (bitc == cfg_wlen);
        load      = fs_go | (mc_en & word_end & ~last);
        next_slot = last ? '0 : slot + 1'b1;
    end

    // transitions: START, NEXT, END, RESYNC, OFF
    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_IDLE:  if (fs_go) st_nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (fs_go)                 st_nxt = ST_SHIFT;
                else if (word_end && last) st_nxt = ST_DONE;
            end
            ST_DONE:  if (fs_go) st_nxt = ST_SHIFT;
            default:  st_nxt = ST_IDLE;
        endcase
        if (!mc_en) st_nxt = ST_IDLE;
    end

    // slot and bit counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            bitc <= '0;
        end else if (fs_go) begin
            slot <= '0;
            bitc <= '0;
        end else if (state == ST_SHIFT) begin
            if (word_end) begin
                if (!last) slot <= slot + 1'b1;
                bitc <= '0;
            end else begin
                bitc <= bitc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_tx_path.sv
`timescale 1ns/1ps
module tdm_tx_path #(
    parameter int WORD_W = 16,
    parameter int BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              load,
    input  logic              shift_en,
    input  logic              slot_en,
    input  logic [BIT_W-1:0]  cfg_wlen,
    output logic              dt,
    output logic              dt_oe
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sr_q;
    logic [BIT_W-1:0]  shamt;

    assign shamt = TOP_BIT - cfg_wlen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            sr_q   <= '0;
        end else begin
            if (tx_wr) hold_q <= tx_wdata;
            if (load)          sr_q <= hold_q << shamt;
            else if (shift_en) sr_q <= sr_q << 1;
        end
    end

    always_comb begin
        dt_oe = shift_en & slot_en;
        dt    = dt_oe & sr_q[WORD_W-1];
    end
endmodule

// File: rtl/tdm_rx_path.sv
`timescale 1ns/1ps
module tdm_rx_path #(
    parameter int WORD_W = 16,
    parameter int BIT_W  = 4,
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              dr,
    input  logic              capture,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BIT_W-1:0]  cfg_wlen,
    input  logic              rx_rd,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              rx_ovf
);
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] keep;
    logic [WORD_W-1:0] cap_word;
    logic              pend_q;

    for (genvar i = 0; i < WORD_W; i++) begin : g_keep
        assign keep[i] = (BIT_W'(i) <= cfg_wlen);
    end

    assign cap_word = {sr_q[WORD_W-2:0], dr} & keep;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_slot  <= '0;
            rx_ovf   <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (shift_en) sr_q <= {sr_q[WORD_W-2:0], dr};
            rx_valid <= capture;
            if (capture) begin
                rx_data <= cap_word;
                rx_slot <= slot;
                rx_ovf  <= pend_q & ~rx_rd;
                pend_q  <= 1'b1;
            end else begin
                rx_ovf <= 1'b0;
                if (rx_rd) pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_engine.sv
`timescale 1ns/1ps
module tdm_slot_engine
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    parameter int WORD_W    = 16,
    localparam int SLOT_W   = $clog2(MAX_SLOTS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mc_en,
    input  logic                 fsync,
    input  logic [SLOT_W-1:0]    cfg_nslots,
    input  logic [BIT_W-1:0]     cfg_wlen,
    input  logic                 cfg_law,
    input  logic [MAX_SLOTS-1:0] tx_mask,
    input  logic [MAX_SLOTS-1:0] rx_mask,
    input  logic                 tx_wr,
    input  logic [WORD_W-1:0]    tx_wdata,
    output logic                 tx_req,
    output logic [SLOT_W-1:0]    tx_req_slot,
    output logic                 dt,
    output logic                 dt_oe,
    input  logic                 dr,
    output logic                 rx_valid,
    output logic [WORD_W-1:0]    rx_data,
    output logic [SLOT_W-1:0]    rx_slot,
    input  logic                 rx_rd,
    output logic                 rx_ovf,
    output logic                 law_out
);
    tdm_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] next_slot;
    logic [BIT_W-1:0]  bitc;
    logic              load;
    logic              word_end;
    logic              shift_en;
    logic              capture;

    tdm_slot_ctrl #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .fsync(fsync),
        .cfg_nslots(cfg_nslots), .cfg_wlen(cfg_wlen),
        .state(state), .slot(slot), .bitc(bitc), .load(load),
        .word_end(word_end), .next_slot(next_slot)
    );

    assign shift_en = (state == ST_SHIFT);
    assign capture  = mc_en & word_end & rx_mask[slot];

    tdm_tx_path #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .load(load), .shift_en(shift_en), .slot_en(tx_mask[slot]),
        .cfg_wlen(cfg_wlen), .dt(dt), .dt_oe(dt_oe)
    );

    tdm_rx_path #(.WORD_W(WORD_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dr(dr),
        .capture(capture), .slot(slot), .cfg_wlen(cfg_wlen), .rx_rd(rx_rd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_slot(rx_slot),
        .rx_ovf(rx_ovf)
    );

    // request for the following slot, raised in the first bit of a slot
    always_comb begin
        tx_req      = shift_en && (bitc == '0) && tx_mask[next_slot];
        tx_req_slot = next_slot;
    end

    // companding select captured once per frame
    always_ff @(posedge clk) begin
        if (!rst_n)              law_out <= 1'b0;
        else if (mc_en && fsync) law_out <= cfg_law;
    end
endmodule

// File: rtl/tdm_slot_engine_chk.sv
`timescale 1ns/1ps
module tdm_slot_engine_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mc_en,
    input logic              fsync,
    input logic              tx_req,
    input logic              dt_oe,
    input logic              rx_valid,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_ovf,
    input logic              law_out
);
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    // R7
    ovf_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> rx_valid);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_en |=> (!dt_oe && !tx_req && !rx_valid));

    // R10
    law_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mc_en && fsync) |=> $stable(law_out));
endmodule

bind tdm_slot_engine tdm_slot_engine_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .fsync(fsync),
    .tx_req(tx_req), .dt_oe(dt_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ovf(rx_ovf), .law_out(law_out)
);

// File: tb/tdm_slot_engine_bench.sv
`timescale 1ns/1ps
module tdm_slot_engine_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mc_en = 1'b0;
    logic         fsync = 1'b0;
    logic [6:0]   cfg_nslots = '0;
    logic [3:0]   cfg_wlen = 4'd7;
    logic         cfg_law = 1'b0;
    logic [127:0] tx_mask = '0;
    logic [127:0] rx_mask = '0;
    logic         tx_wr = 1'b0;
    logic [15:0]  tx_wdata = '0;
    logic         tx_req;
    logic [6:0]   tx_req_slot;
    logic         dt, dt_oe;
    logic         dr = 1'b0;
    logic         rx_valid;
    logic [15:0]  rx_data;
    logic [6:0]   rx_slot;
    logic         rx_rd = 1'b0;
    logic         rx_ovf;
    logic         law_out;

    always #5 clk = ~clk;

    tdm_slot_engine u_tdm_slot_engine (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .fsync(fsync),
        .cfg_nslots(cfg_nslots), .cfg_wlen(cfg_wlen), .cfg_law(cfg_law),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .tx_req(tx_req), .tx_req_slot(tx_req_slot),
        .dt(dt), .dt_oe(dt_oe), .dr(dr), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_slot(rx_slot), .rx_rd(rx_rd),
        .rx_ovf(rx_ovf), .law_out(law_out)
    );

    int errors = 0;
    int checks = 0;
    bit checking = 0;
    bit rd_auto = 1;
    bit collect = 0;
    bit finished = 0;
    int valid_cnt = 0;
    int ovf_cnt = 0;
    int cap_q[$];

    task automatic chk(input longint act, input longint exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // serial receive data source
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dr = lfsr[0];
    end

    // host: answer requests and acknowledge words
    int wcnt = 0;
    always @(posedge clk) begin
        #2;
        tx_wr = tx_req;
        if (tx_req) begin
            tx_wdata = 16'(wcnt * 16'h03B5 + 16'h9A61);
            wcnt++;
        end
        rx_rd = rd_auto && rx_valid;
    end

    // reference model state
    int  mst, mslot, mbit, mword, hold, racc, wl, word;
    bit  wend, cap, pend;
    bit  e_valid, e_ovf, e_law;
    int  e_data, e_slot;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mslot = 0; mbit = 0; mword = 0; hold = 0; racc = 0;
            e_valid = 0; e_ovf = 0; e_law = 0; e_data = 0; e_slot = 0; pend = 0;
        end else begin
            wl   = int'(cfg_wlen);
            wend = (mst == 1) && (mbit == wl);
            cap  = mc_en && wend && rx_mask[mslot];
            word = ((racc << 1) | int'(dr)) & ((1 << (wl + 1)) - 1);
            e_valid = cap;
            if (cap) begin
                e_ovf = pend && !rx_rd;
                pend = 1;
                e_data = word;
                e_slot = mslot;
            end else begin
                e_ovf = 0;
                if (rx_rd) pend = 0;
            end
            if (!mc_en) mst = 0;
            else if (fsync) begin
                mst = 1; mslot = 0; mbit = 0; mword = hold; racc = 0; e_law = cfg_law;
            end else if (mst == 1) begin
                if (wend) begin
                    if (mslot == int'(cfg_nslots)) mst = 2;
                    else begin
                        mslot++; mbit = 0; mword = hold; racc = 0;
                    end
                end else begin
                    mbit++;
                    racc = (racc << 1) | int'(dr);
                end
            end
            if (tx_wr) hold = int'(tx_wdata);
        end
    end

    // compare on every cycle, mid-period
    int    nxt;
    bit    x_oe, x_dt, x_req;
    string otag;
    always @(negedge clk) begin
        if (rst_n && checking) begin
            x_oe = (mst == 1) && tx_mask[mslot];
            x_dt = x_oe ? bit'((mword >> (int'(cfg_wlen) - mbit)) & 1) : 1'b0;
            otag = x_oe ? "R3" : ((mst == 1) ? "R4" : "R9");
            chk(dt_oe, x_oe, otag, "dt_oe");
            chk(dt, x_dt, otag, "dt");
            nxt = (mslot == int'(cfg_nslots)) ? 0 : mslot + 1;
            x_req = (mst == 1) && (mbit == 0) && tx_mask[nxt];
            chk(tx_req, x_req, "R8", "tx_req");
            if (x_req) chk(tx_req_slot, nxt, "R8", "tx_req_slot");
            chk(rx_valid, e_valid, e_valid ? "R5" : "R6", "rx_valid");
            chk(rx_data, e_data, e_valid ? "R5" : "R6", "rx_data");
            chk(rx_slot, e_slot, e_valid ? "R5" : "R6", "rx_slot");
            chk(rx_ovf, e_ovf, "R7", "rx_ovf");
            chk(law_out, e_law, "R10", "law_out");
        end
        if (rx_valid) begin
            valid_cnt++;
            if (collect) cap_q.push_back(int'(rx_slot));
        end
        if (rx_ovf) ovf_cnt++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_sync();
        @(posedge clk); #1; fsync = 1'b1;
        @(posedge clk); #1; fsync = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int exp_slots[$];
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dt_oe, 0, "R1", "dt_oe");
        chk(tx_req, 0, "R1", "tx_req");
        chk(rx_valid, 0, "R1", "rx_valid");
        chk(rx_ovf, 0, "R1", "rx_ovf");
        chk(law_out, 0, "R1", "law_out");
        chk(rx_data, 0, "R1", "rx_data");
        checking = 1;

        // 8 slots of 8 bits, mixed masks
        step(1);
        mc_en = 1'b1; cfg_nslots = 7'd7; cfg_wlen = 4'd7; cfg_law = 1'b1;
        tx_mask = 128'b1011_0101; rx_mask = 128'b0110_1011;
        pulse_sync();
        // R2: slot 0 ends wlen+1 cycles after the sync is taken
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(rx_valid, 1, "R2", "slot0 end strobe");
        chk(rx_slot, 0, "R2", "slot0 index");
        step(70);
        cfg_law = 1'b0;
        pulse_sync();
        step(20);
        cfg_law = 1'b1;   // R10: mid-frame change must wait for sync
        step(60);

        // 4 slots of 16 bits, wrap request for slot 0
        cfg_nslots = 7'd3; cfg_wlen = 4'd15;
        tx_mask = 128'b1001; rx_mask = 128'b1110;
        pulse_sync();
        step(70);
        pulse_sync();
        step(70);

        // R7 overflow: no acknowledges for a frame
        rd_auto = 0;
        cfg_nslots = 7'd5; cfg_wlen = 4'd4;
        rx_mask = 128'b11_1011; tx_mask = 128'b01_0110;
        step(2);
        ovf_cnt = 0;
        pulse_sync();
        step(40);
        chk(ovf_cnt, 4, "R7", "overflow pulses in frame");
        rd_auto = 1;
        step(2);

        // fsync in the middle of a word (R2 restart)
        cfg_nslots = 7'd3; cfg_wlen = 4'd7;
        rx_mask = 128'b1111; tx_mask = 128'b0111;
        pulse_sync();
        step(11);
        pulse_sync();
        step(40);

        // R9: drop enable mid-frame, sync while off
        pulse_sync();
        step(5);
        mc_en = 1'b0;
        step(2);
        valid_cnt = 0;
        pulse_sync();
        step(40);
        chk(valid_cnt, 0, "R9", "captures while disabled");
        mc_en = 1'b1;
        step(3);

        // R11: full 128-slot frame, bits in upper groups
        cfg_nslots = 7'd127; cfg_wlen = 4'd2;
        rx_mask = '0; tx_mask = '0;
        rx_mask[3] = 1; rx_mask[17] = 1; rx_mask[64] = 1; rx_mask[100] = 1; rx_mask[127] = 1;
        tx_mask[0] = 1; tx_mask[16] = 1; tx_mask[99] = 1; tx_mask[127] = 1;
        exp_slots = '{3, 17, 64, 100, 127};
        step(2);
        cap_q.delete();
        collect = 1;
        pulse_sync();
        step(128 * 3 + 6);
        collect = 0;
        chk(cap_q.size(), exp_slots.size(), "R11", "capture count");
        foreach (exp_slots[i]) begin
            if (i < cap_q.size()) chk(cap_q[i], exp_slots[i], "R11", "captured slot index");
        end
        step(5);
        finish_run();
    end
endmodule